// File: doc/BRIEF.md
# Self-programming write sequencer for on-chip nonvolatile memory

This block is the firmware-facing front end for self-programming of on-chip nonvolatile storage. Firmware selects a target space (data EEPROM, program memory or configuration storage) and, optionally, an erase. It stages one block of bytes through a table latch and a 24-bit-style table pointer into a bank of holding registers. A guarded start bit then launches the operation. A busy timer with a programmable length runs for the whole operation. When it expires, the block issues a single-cycle command to the memory array model: the space, the erase flag, the block address and the full holding bank. It also raises a sticky completion flag.

Starting an operation is guarded. Two key bytes must go to a key register that holds no data, back to back, and write-enable must already be set. Only then does a start request take effect. A request that fails these checks is dropped and sets an error bit. A warm reset that arrives in the middle of an operation also sets the error bit. A power-on reset clears everything.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: After power-on reset, the control register (address 0) reads 0x00, the timing register (address 6) reads 20, `irq` is low and every holding byte on `cmd_data` is 0xFF.
- R2: `cmd_space` is 2 when the config bit (control bit 4) is set, regardless of the target bit (control bit 5). Otherwise it is 1 when the target bit is set and 0 when it is clear.
- R3: `cmd_erase` carries the erase bit (control bit 3) of the operation being issued.
- R4: A start request (control write with bit 0 set) made while write-enable (bit 1) is clear is ignored and sets the error bit (bit 2). Write-enable is 0 after reset.
- R5: A start request takes effect only if the two register accesses just before it were writes of 0x55 and then 0xAA to the key register (address 1). Otherwise it is ignored and sets the error bit.
- R6: Once set, the start bit reads 1 and firmware cannot clear it. With timing value T, `cmd_valid` pulses in the (T+1)-th cycle after the start write, and the start bit clears at the next edge.
- R7: The done flag (control bit 6) and `irq` rise after `cmd_valid`. Writing 1 to bit 6 keeps the flag; writing 0 clears it.
- R8: The key register always reads 0x00.
- R9: A `tbl_wr` pulse copies the latch (address 2) into holding byte `ptr[3:0]`, which appears at `cmd_data[8*i +: 8]`. The pointer is built from addresses 3 (bits 7:0), 4 (bits 15:8) and 5 (bits 20:16). `cmd_block` equals `ptr[20:4]`.
- R10: After a non-erase operation, every holding byte returns to 0xFF. An erase leaves the holding bytes unchanged.
- R11: A warm reset while an operation runs aborts it with no `cmd_valid`, clears the start bit and write-enable, and sets the error bit. A control write with bit 2 at 0 clears the error bit.
- R12: While an operation runs, `tbl_wr`, pointer writes and control writes to bits 3 to 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst_n | input | 1 | Synchronous warm reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| tbl_wr | input | 1 | Table-write strobe, latch into holding byte |
| cmd_valid | output | 1 | One-cycle command to the memory array |
| cmd_erase | output | 1 | Command is an erase |
| cmd_space | output | 2 | Target space: 0 data, 1 program, 2 config |
| cmd_block | output | 17 | Block address from the upper pointer bits |
| cmd_data | output | 128 | Holding bank, byte i at bits 8i+7:8i |
| irq | output | 1 | Completion flag |

## Verification
The hardest states to reach are the ones that depend on what happened between key writes and on when a warm reset lands. One case is a stray register read placed between the two key bytes. Another is a warm reset that arrives while the busy timer is still counting down. The bench places a read of the latch register exactly between 0x55 and 0xAA and also sends the keys in reverse order. It raises warm reset a few cycles into a 10-cycle operation and then watches for a `cmd_valid` that must never come. Busy-time protection is tested by issuing control, latch, pointer and table writes in the middle of a long operation and then comparing the issued command against values computed before the launch.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;
   typedef enum logic [2:0] {
      RA_CTRL    = 3'd0,
      RA_KEY     = 3'd1,
      RA_LATCH   = 3'd2,
      RA_PTR_LO  = 3'd3,
      RA_PTR_MID = 3'd4,
      RA_PTR_HI  = 3'd5,
      RA_TIME    = 3'd6
   } reg_addr_e;

   localparam int CB_START = 0;
   localparam int CB_WREN  = 1;
   localparam int CB_ERR   = 2;
   localparam int CB_ERASE = 3;
   localparam int CB_CFG   = 4;
   localparam int CB_TGT   = 5;
   localparam int CB_DONE  = 6;

   typedef enum logic [1:0] {
      SP_DATA = 2'd0,
      SP_PROG = 2'd1,
      SP_CFG  = 2'd2
   } space_e;

   typedef enum logic [1:0] {
      UL_IDLE = 2'd0,
      UL_HALF = 2'd1,
      UL_OPEN = 2'd2
   } unl_state_e;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
   import nvm_wr_pkg::*;
#(
   parameter logic [7:0] KEY_A = 8'h55,
   parameter logic [7:0] KEY_B = 8'hAA
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       abort,
   input  logic       access,
   input  logic       key_wr,
   input  logic [7:0] wdata,
   output logic       open
);
   unl_state_e st_q, st_d;

   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("nvm_unlock: the two keys must differ");
   end

   always_comb begin
      st_d = st_q;
      if (key_wr) begin
         if (wdata == KEY_A)                          st_d = UL_HALF;
         else if (wdata == KEY_B && st_q == UL_HALF)  st_d = UL_OPEN;
         else                                         st_d = UL_IDLE;
      end else if (access) begin
         st_d = UL_IDLE;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      st_q <= UL_IDLE;
      else if (abort)  st_q <= UL_IDLE;
      else             st_q <= st_d;
   end

   assign open = (st_q == UL_OPEN);

   // R5: the sequence opens only right after the second key is written
   a_r5_open_needs_key: assert property (@(posedge clk) disable iff (!por_n)
      $rose(open) |-> $past(key_wr && wdata == KEY_B));
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             abort,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             run,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_w
      $error("nvm_busy_timer: CNT_W out of range");
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         run   <= 1'b0;
         cnt_q <= '0;
      end else if (abort) begin
         run   <= 1'b0;
         cnt_q <= '0;
      end else if (load) begin
         run   <= 1'b1;
         cnt_q <= load_val;
      end else if (run) begin
         if (cnt_q == '0) run   <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = run && (cnt_q == '0);

   // R6: while counting, the timer keeps running and decrements by one
   a_r6_count_down: assert property (@(posedge clk) disable iff (!por_n || abort)
      (run && cnt_q != '0) |=> (run && cnt_q == $past(cnt_q) - 1'b1));
   // R6: expiry ends the run
   a_r6_expire_stops: assert property (@(posedge clk) disable iff (!por_n || abort)
      (expire && !load) |=> !run);
endmodule

// File: rtl/nvm_hold_bank.sv
module nvm_hold_bank #(
   parameter int BYTES = 16,
   localparam int IDX_W = $clog2(BYTES)
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [7:0]         wr_data,
   input  logic               clr,
   output logic [BYTES*8-1:0] flat
);
   if (BYTES < 2 || (1 << IDX_W) != BYTES) begin : g_bad_bytes
      $error("nvm_hold_bank: BYTES must be a power of two, at least 2");
   end

   for (genvar i = 0; i < BYTES; i++) begin : g_byte
      logic [7:0] b_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                                 b_q <= 8'hFF;
         else if (clr)                               b_q <= 8'hFF;
         else if (wr_en && wr_idx == IDX_W'(i))      b_q <= wr_data;
      end
      assign flat[8*i +: 8] = b_q;
   end

   // R10: a clear request leaves every byte erased
   a_r10_clear_to_ff: assert property (@(posedge clk) disable iff (!por_n)
      clr |=> (flat == '1));
   // R9: a write without clear lands in the addressed byte
   a_r9_write_lands: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && !clr) |=> (flat[8*$past(wr_idx) +: 8] == $past(wr_data)));
endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl
   import nvm_wr_pkg::*;
#(
   parameter int         HOLD_BYTES = 16,
   parameter int         PTR_W      = 21,
   parameter logic [7:0] TIME_RST   = 8'd20,
   parameter logic [7:0] KEY_A      = 8'h55,
   parameter logic [7:0] KEY_B      = 8'hAA,
   localparam int        IDX_W      = $clog2(HOLD_BYTES),
   localparam int        BLK_W      = PTR_W - IDX_W,
   localparam int        DATA_W     = HOLD_BYTES * 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              tbl_wr,
   output logic              cmd_valid,
   output logic              cmd_erase,
   output logic [1:0]        cmd_space,
   output logic [BLK_W-1:0]  cmd_block,
   output logic [DATA_W-1:0] cmd_data,
   output logic              irq
);
   if (PTR_W < 17 || PTR_W > 23) begin : g_bad_ptr
      $error("nvm_wr_ctrl: PTR_W must lie in 17..23");
   end
   if (IDX_W >= 8) begin : g_bad_hold
      $error("nvm_wr_ctrl: holding index must fit the low pointer byte");
   end

   logic             wren_q, erase_q, cfg_q, tgt_q, err_q, done_q;
   logic [7:0]       latch_q, time_q;
   logic [PTR_W-1:0] ptr_q;
   logic             run, expire, unl_open, done_evt;
   logic             ctrl_wr, key_wr, start_req, start_ok, start_bad, access;

   assign access    = bus_wr || bus_rd;
   assign ctrl_wr   = bus_wr && (bus_addr == RA_CTRL);
   assign key_wr    = bus_wr && (bus_addr == RA_KEY);
   assign start_req = warm_rst_n && ctrl_wr && bus_wdata[CB_START] && !run;
   assign start_ok  = start_req && unl_open && wren_q;
   assign start_bad = start_req && !start_ok;
   assign done_evt  = expire && warm_rst_n;

   nvm_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) i_unlock (
      .clk    (clk),
      .por_n  (por_n),
      .abort  (!warm_rst_n),
      .access (access),
      .key_wr (key_wr),
      .wdata  (bus_wdata),
      .open   (unl_open)
   );

   nvm_busy_timer #(.CNT_W(8)) i_timer (
      .clk      (clk),
      .por_n    (por_n),
      .abort    (!warm_rst_n),
      .load     (start_ok),
      .load_val (time_q),
      .run      (run),
      .expire   (expire)
   );

   nvm_hold_bank #(.BYTES(HOLD_BYTES)) i_hold (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (tbl_wr && !run && warm_rst_n),
      .wr_idx  (ptr_q[IDX_W-1:0]),
      .wr_data (latch_q),
      .clr     (done_evt && !erase_q),
      .flat    (cmd_data)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wren_q  <= 1'b0;
         erase_q <= 1'b0;
         cfg_q   <= 1'b0;
         tgt_q   <= 1'b0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
         latch_q <= 8'h00;
         ptr_q   <= '0;
         time_q  <= TIME_RST;
      end else if (!warm_rst_n) begin
         wren_q <= 1'b0;
         if (run) err_q <= 1'b1;
      end else begin
         if (ctrl_wr) begin
            wren_q <= bus_wdata[CB_WREN];
            if (!run) begin
               erase_q <= bus_wdata[CB_ERASE];
               cfg_q   <= bus_wdata[CB_CFG];
               tgt_q   <= bus_wdata[CB_TGT];
            end
            if (!bus_wdata[CB_DONE]) done_q <= 1'b0;
            err_q <= (err_q && bus_wdata[CB_ERR]) || start_bad;
         end
         if (done_evt) done_q <= 1'b1;
         if (bus_wr) begin
            unique case (bus_addr)
               RA_LATCH:   latch_q <= bus_wdata;
               RA_TIME:    time_q  <= bus_wdata;
               RA_PTR_LO:  if (!run) ptr_q[7:0]        <= bus_wdata;
               RA_PTR_MID: if (!run) ptr_q[15:8]       <= bus_wdata;
               RA_PTR_HI:  if (!run) ptr_q[PTR_W-1:16] <= bus_wdata[PTR_W-17:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (bus_addr)
         RA_CTRL:    bus_rdata = {1'b0, done_q, tgt_q, cfg_q, erase_q, err_q, wren_q, run};
         RA_LATCH:   bus_rdata = latch_q;
         RA_PTR_LO:  bus_rdata = ptr_q[7:0];
         RA_PTR_MID: bus_rdata = ptr_q[15:8];
         RA_PTR_HI:  bus_rdata = {{(24-PTR_W){1'b0}}, ptr_q[PTR_W-1:16]};
         RA_TIME:    bus_rdata = time_q;
         default:    bus_rdata = 8'h00;
      endcase
   end

   assign cmd_valid = done_evt;
   assign cmd_erase = erase_q;
   assign cmd_space = cfg_q ? SP_CFG : (tgt_q ? SP_PROG : SP_DATA);
   assign cmd_block = ptr_q[PTR_W-1:IDX_W];
   assign irq       = done_q;

   // R5 / R4: an operation only begins after an open sequence with write-enable
   a_r5_start_guarded: assert property (@(posedge clk) disable iff (!por_n)
      $rose(run) |-> $past(unl_open && wren_q));
   // R7: completion raises the sticky flag
   a_r7_done_after_cmd: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
      cmd_valid |=> (irq && !run));
   // R8: the key register reads as zero
   a_r8_key_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
      (bus_rd && bus_addr == RA_KEY) |-> (bus_rdata == 8'h00));
   // R11: a warm reset during an operation aborts it and flags an error
   a_r11_warm_abort: assert property (@(posedge clk) disable iff (!por_n)
      (run && !warm_rst_n) |=> (err_q && !run));
   // R12: the holding bank and pointer are frozen while busy
   a_r12_busy_frozen: assert property (@(posedge clk) disable iff (!por_n)
      (run && !cmd_valid) |=> ($stable(cmd_data) && $stable(cmd_block)));
endmodule

// File: tb/test_nvm_wr_ctrl.sv
`timescale 1ns/1ps
module test_nvm_wr_ctrl;
   logic         clk = 1'b0;
   logic         por_n = 1'b0;
   logic         warm_rst_n = 1'b1;
   logic         bus_wr = 1'b0, bus_rd = 1'b0, tbl_wr = 1'b0;
   logic [2:0]   bus_addr = 3'd0;
   logic [7:0]   bus_wdata = 8'h00;
   logic [7:0]   bus_rdata;
   logic         cmd_valid, cmd_erase, irq;
   logic [1:0]   cmd_space;
   logic [16:0]  cmd_block;
   logic [127:0] cmd_data;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   nvm_wr_ctrl i_nvm_wr_ctrl (
      .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tbl_wr(tbl_wr),
      .cmd_valid(cmd_valid), .cmd_erase(cmd_erase), .cmd_space(cmd_space),
      .cmd_block(cmd_block), .cmd_data(cmd_data), .irq(irq)
   );

   localparam logic [2:0] A_CTRL = 3'd0, A_KEY = 3'd1, A_LATCH = 3'd2,
                          A_LO = 3'd3, A_MID = 3'd4, A_HI = 3'd5, A_TIME = 3'd6;

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic tbl_pulse();
      @(negedge clk); tbl_wr = 1'b1;
      @(negedge clk); tbl_wr = 1'b0;
   endtask

   task automatic launch(input logic [7:0] ctrl);
      wr(A_KEY, 8'h55);
      wr(A_KEY, 8'hAA);
      wr(A_CTRL, ctrl | 8'h01);
   endtask

   task automatic wait_cmd(output int cyc);
      cyc = 0;
      while (!cmd_valid && cyc < 300) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic no_cmd_for(input int n, input string req);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (cmd_valid) seen++;
      end
      chk(seen == 0, req, seen, 0);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(A_CTRL, d); chk(d == 8'h00, "R1 ctrl", d, 8'h00);
      rd(A_TIME, d); chk(d == 8'd20, "R1 time", d, 8'd20);
      chk(irq == 1'b0, "R1 irq", irq, 0);
      chk(cmd_data == '1, "R1 hold", cmd_data, '1);
      rd(A_KEY, d); chk(d == 8'h00, "R8 key read", d, 0);
   endtask

   task automatic t_prog();
      logic [7:0] d; logic [127:0] exp; int cyc;
      wr(A_TIME, 8'd3);
      wr(A_HI, 8'h01); wr(A_MID, 8'h23); wr(A_LO, 8'h45);
      wr(A_LATCH, 8'hA5); tbl_pulse();
      wr(A_LO, 8'h4F); wr(A_LATCH, 8'h3C); tbl_pulse();
      exp = '1; exp[8*5 +: 8] = 8'hA5; exp[8*15 +: 8] = 8'h3C;
      chk(cmd_data == exp, "R9 staged bytes", cmd_data, exp);
      wr(A_CTRL, 8'h22);
      launch(8'h22);
      rd(A_CTRL, d); chk(d[0] == 1'b1, "R6 start reads 1", d, 8'h23);
      wait_cmd(cyc);
      chk(cyc == 1, "R6 busy length T=3", cyc, 1);
      chk(cmd_space == 2'd1, "R2 program space", cmd_space, 1);
      chk(cmd_erase == 1'b0, "R3 write not erase", cmd_erase, 0);
      chk(cmd_block == 17'h01234, "R9 block", cmd_block, 17'h01234);
      chk(cmd_data == exp, "R9 data issued", cmd_data, exp);
      rd(A_CTRL, d); chk(d == 8'h62, "R7 done set start clear", d, 8'h62);
      chk(irq == 1'b1, "R7 irq", irq, 1);
      chk(cmd_data == '1, "R10 hold reset after write", cmd_data, '1);
   endtask

   task automatic t_done_sticky();
      logic [7:0] d;
      wr(A_CTRL, 8'h62); rd(A_CTRL, d);
      chk(d == 8'h62 && irq, "R7 flag kept by writing 1", d, 8'h62);
      wr(A_CTRL, 8'h22); rd(A_CTRL, d);
      chk(d == 8'h22 && !irq, "R7 flag cleared by writing 0", d, 8'h22);
   endtask

   task automatic t_timer0();
      int cyc;
      wr(A_TIME, 8'd0);
      wr(A_CTRL, 8'h02);
      launch(8'h02);
      chk(cmd_valid == 1'b1, "R6 T=0 immediate", cmd_valid, 1);
      wait_cmd(cyc);
      chk(cyc == 0, "R6 T=0 one busy cycle", cyc, 0);
      chk(cmd_space == 2'd0, "R2 data space", cmd_space, 0);
   endtask

   task automatic t_timed();
      int cyc;
      wr(A_TIME, 8'd9);
      wr(A_CTRL, 8'h02);
      launch(8'h02);
      wait_cmd(cyc);
      chk(cyc == 9, "R6 busy length T=9", cyc, 9);
   endtask

   task automatic t_busy();
      logic [7:0] d; logic [127:0] exp; int cyc;
      wr(A_TIME, 8'd20);
      wr(A_LATCH, 8'h11); tbl_pulse();
      exp = '1; exp[8*15 +: 8] = 8'h11;
      wr(A_CTRL, 8'h3A);
      launch(8'h3A);
      wr(A_CTRL, 8'h02);
      rd(A_CTRL, d); chk(d == 8'h3B, "R6 start not cleared / R12 mode held", d, 8'h3B);
      wr(A_LATCH, 8'h99); tbl_pulse();
      wr(A_LO, 8'h00);
      wait_cmd(cyc);
      chk(cmd_valid == 1'b1, "R12 op still completes", cmd_valid, 1);
      chk(cmd_erase == 1'b1, "R3 erase issued", cmd_erase, 1);
      chk(cmd_space == 2'd2, "R2 cfg overrides target", cmd_space, 2);
      chk(cmd_block == 17'h01234, "R12 pointer write ignored", cmd_block, 17'h01234);
      chk(cmd_data == exp, "R12 table write ignored", cmd_data, exp);
      @(negedge clk);
      chk(cmd_data == exp, "R10 erase keeps hold", cmd_data, exp);
      rd(A_LO, d); chk(d == 8'h4F, "R12 pointer unchanged", d, 8'h4F);
   endtask

   task automatic t_no_wren();
      logic [7:0] d;
      wr(A_CTRL, 8'h00);
      launch(8'h00);
      no_cmd_for(12, "R4 no command without wren");
      rd(A_CTRL, d); chk(d == 8'h04, "R4 error set, start clear", d, 8'h04);
      wr(A_CTRL, 8'h02); rd(A_CTRL, d);
      chk(d == 8'h02, "R11 error cleared by writing 0", d, 8'h02);
   endtask

   task automatic t_bad_unlock();
      logic [7:0] d;
      wr(A_KEY, 8'h55); rd(A_LATCH, d); wr(A_KEY, 8'hAA); wr(A_CTRL, 8'h03);
      no_cmd_for(12, "R5 read between keys");
      rd(A_CTRL, d); chk(d == 8'h06, "R5 error after broken sequence", d, 8'h06);
      wr(A_CTRL, 8'h02);
      wr(A_KEY, 8'hAA); wr(A_KEY, 8'h55); wr(A_CTRL, 8'h03);
      no_cmd_for(12, "R5 keys reversed");
      rd(A_CTRL, d); chk(d == 8'h06, "R5 error after reversed keys", d, 8'h06);
      wr(A_CTRL, 8'h02);
      wr(A_KEY, 8'h55); rd(A_KEY, d);
      chk(d == 8'h00, "R8 key reads zero after write", d, 0);
   endtask

   task automatic t_warm();
      logic [7:0] d;
      wr(A_TIME, 8'd10);
      wr(A_CTRL, 8'h22);
      launch(8'h22);
      @(negedge clk); @(negedge clk);
      warm_rst_n = 1'b0;
      @(negedge clk);
      warm_rst_n = 1'b1;
      no_cmd_for(16, "R11 aborted op issues nothing");
      rd(A_CTRL, d); chk(d == 8'h24, "R11 abort state", d, 8'h24);
   endtask

   initial begin
      #(20 * 100000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prog();
      t_done_sticky();
      t_timer0();
      t_timed();
      t_busy();
      t_no_wren();
      t_bad_unlock();
      t_warm();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule